// File: doc/BRIEF.md
# Row-Aware Variable-Latency Read Responder

This block is the read side of a simulated memory target on an AXI4 bus. It accepts read address requests, waits out an access delay that depends on the memory row being addressed, and then returns the burst data. The delay imitates a memory that keeps one row open. A read into the open row costs a short base delay. A read into any other row also pays a precharge-plus-activate penalty, and its row then becomes the open row. No row is open after reset.

Address acceptance is decoupled from data return. Accepted requests wait in a small queue, each tagged with the cycle at which its data becomes available. New addresses are accepted while older reads are still waiting or streaming, so their delays overlap instead of adding up. Data comes back in request order with no interleaving. Each beat's payload is the beat address XORed with a fixed pattern, so a checker can predict every word.

Top module: `lat_rd_responder`

## Requirements
- R1: While reset is asserted and right after it is released, ar_ready is 1 and r_valid is 0.
- R2: A read whose row field (address bits ROW_LSB upward, ROW_W wide) equals the open row gets delay D = HIT_DLY. If the return channel is idle, r_valid for that read rises D clock edges after its address handshake edge.
- R3: A read to a different row, or the first read after reset, gets D = HIT_DLY + MISS_PEN. Its row becomes the open row for every later request.
- R4: The first beat of a read is never presented before D edges have passed since its handshake, even when the return channel is idle.
- R5: Up to DEPTH accepted reads may wait for return while one more streams. ar_ready is 0 exactly while DEPTH reads are waiting.
- R6: Reads return in the order their addresses were accepted. r_id equals the accepted ar_id, and bursts do not interleave.
- R7: A read returns ar_len+1 beats. r_last is 1 only on the final beat, and after a non-final beat handshake r_valid stays 1.
- R8: Beat i carries r_data = (ar_addr + i*DATA_W/8) XOR PATTERN and r_resp = 2'b00 (OKAY).
- R9: While r_valid is 1 and r_ready is 0, r_valid, r_data, r_id and r_last hold their values.
- R10: When the next read's delay has already expired, its first beat is presented in the cycle right after the previous read's last-beat handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Asynchronous active-low reset |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready; low while the wait queue is full |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Burst start byte address |
| ar_len | input | LEN_W | Beats in the burst minus one |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data accepted by the manager |
| r_id | output | ID_W | ID of the returning read |
| r_data | output | DATA_W | Beat payload |
| r_resp | output | 2 | Response code, always OKAY |
| r_last | output | 1 | Final beat of the burst |

## Verification
The bench builds the block with HIT_DLY=2, MISS_PEN=5, ROW_LSB=8 and DEPTH=4. Row changes then come from a few address bits, and a miss costs more than three times a hit, so the exact first-beat cycle tells hits from misses. With a queue of four, stalling r_ready for a few cycles fills the queue and drops ar_ready. Bursts of up to eight beats and short delays make same-edge handoffs between reads common, and mixed rows produce runs of hits and misses in one stream.

// File: rtl/lat_rd_pkg.sv
package lat_rd_pkg;

  typedef enum logic {
    BG_IDLE   = 1'b0,
    BG_STREAM = 1'b1
  } lr_bg_e;

  localparam logic [1:0] LR_RESP_OKAY = 2'b00;

endpackage

// File: rtl/lat_rd_fifo.sv
module lat_rd_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = pop  ? bump(rd_q) : rd_q;
    wr_d  = push ? bump(wr_q) : wr_q;
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop)         rd_q  <= rd_d;
      if (push)        wr_q  <= wr_d;
      if (push ^ pop)  cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH))
    else $error("wait queue holds more than DEPTH entries");

  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty)
    else $error("return logic took an entry from an empty queue");

endmodule

// File: rtl/lat_rd_timer.sv
module lat_rd_timer #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ROW_LSB  = 10,
  parameter int unsigned ROW_W    = 4,
  parameter int unsigned HIT_DLY  = 3,
  parameter int unsigned MISS_PEN = 6,
  parameter int unsigned TIME_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_fire,
  input  logic [ADDR_W-1:0] ar_addr,
  output logic [TIME_W-1:0] now,
  output logic [TIME_W-1:0] due
);
  logic [ROW_W-1:0]  row_q, row_d, ar_row;
  logic              open_q, open_d, hit;
  logic [TIME_W-1:0] now_d;

  assign ar_row = ar_addr[ROW_LSB +: ROW_W];

  always_comb begin
    hit    = open_q && (ar_row == row_q);
    due    = now + (hit ? TIME_W'(HIT_DLY) : TIME_W'(HIT_DLY + MISS_PEN));
    now_d  = now + 1'b1;
    row_d  = row_q;
    open_d = open_q;
    if (ar_fire) begin
      row_d  = ar_row;
      open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now    <= '0;
      row_q  <= '0;
      open_q <= 1'b0;
    end else begin
      now <= now_d;
      if (ar_fire) begin
        row_q  <= row_d;
        open_q <= open_d;
      end
    end
  end

  assert_row_opened_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |=> open_q)
    else $error("no open row after an accepted read");

endmodule

// File: rtl/lat_rd_beats.sv
module lat_rd_beats
  import lat_rd_pkg::*;
#(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TIME_W = 16,
  parameter logic [DATA_W-1:0] PATTERN = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic [ID_W-1:0]   head_id,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [LEN_W-1:0]  head_len,
  input  logic [TIME_W-1:0] head_due,
  input  logic [TIME_W-1:0] now,
  output logic              pop,
  input  logic              r_ready,
  output logic              r_valid,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);
  localparam int unsigned STEP = DATA_W / 8;

  lr_bg_e            st_q, st_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [TIME_W-1:0] gap;
  logic              due_reached, beat_done, finishing, upd;

  always_comb begin
    gap         = now - head_due;
    due_reached = !gap[TIME_W-1];
    beat_done   = (st_q == BG_STREAM) && r_ready;
    finishing   = beat_done && (left_q == '0);
    pop         = head_valid && due_reached && ((st_q == BG_IDLE) || finishing);
    st_d   = st_q;
    id_d   = id_q;
    addr_d = addr_q;
    left_d = left_q;
    if (pop) begin
      st_d   = BG_STREAM;
      id_d   = head_id;
      addr_d = head_addr;
      left_d = head_len;
    end else if (finishing) begin
      st_d = BG_IDLE;
    end else if (beat_done) begin
      addr_d = addr_q + ADDR_W'(STEP);
      left_d = left_q - 1'b1;
    end
    upd = pop || beat_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BG_IDLE;
      id_q   <= '0;
      addr_q <= '0;
      left_q <= '0;
    end else if (upd) begin
      st_q   <= st_d;
      id_q   <= id_d;
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign r_valid = (st_q == BG_STREAM);
  assign r_id    = id_q;
  assign r_data  = DATA_W'(addr_q) ^ PATTERN;
  assign r_resp  = LR_RESP_OKAY;
  assign r_last  = (left_q == '0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_id) && $stable(r_last)))
    else $error("return beat changed while stalled");

  assert_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_ready && !r_last) |=> r_valid)
    else $error("burst stopped before its final beat");

endmodule

// File: rtl/lat_rd_responder.sv
module lat_rd_responder #(
  parameter int unsigned ID_W     = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned HIT_DLY  = 3,
  parameter int unsigned MISS_PEN = 6,
  parameter int unsigned ROW_LSB  = 10,
  parameter int unsigned ROW_W    = 4,
  parameter int unsigned TIME_W   = 16,
  parameter logic [DATA_W-1:0] PATTERN = 32'hA5C3_0F96
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);
  localparam int unsigned ENT_W = ID_W + ADDR_W + LEN_W + TIME_W;

  logic              ar_fire, q_full, q_empty, q_pop;
  logic [TIME_W-1:0] now, due;
  logic [ENT_W-1:0]  q_din, q_dout;
  logic [ID_W-1:0]   h_id;
  logic [ADDR_W-1:0] h_addr;
  logic [LEN_W-1:0]  h_len;
  logic [TIME_W-1:0] h_due;

  assign ar_ready = !q_full;
  assign ar_fire  = ar_valid && ar_ready;
  assign q_din    = {ar_id, ar_addr, ar_len, due};
  assign {h_id, h_addr, h_len, h_due} = q_dout;

  lat_rd_timer #(
    .ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB), .ROW_W(ROW_W),
    .HIT_DLY(HIT_DLY), .MISS_PEN(MISS_PEN), .TIME_W(TIME_W)
  ) u_timer (
    .clk(aclk), .rst_n(aresetn), .ar_fire(ar_fire), .ar_addr(ar_addr),
    .now(now), .due(due)
  );

  lat_rd_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_queue (
    .clk(aclk), .rst_n(aresetn), .push(ar_fire), .din(q_din),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  lat_rd_beats #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
    .TIME_W(TIME_W), .PATTERN(PATTERN)
  ) u_beats (
    .clk(aclk), .rst_n(aresetn), .head_valid(!q_empty), .head_id(h_id),
    .head_addr(h_addr), .head_len(h_len), .head_due(h_due), .now(now),
    .pop(q_pop), .r_ready(r_ready), .r_valid(r_valid), .r_id(r_id),
    .r_data(r_data), .r_resp(r_resp), .r_last(r_last)
  );

endmodule

// File: tb/lat_rd_responder_bench.sv
`timescale 1ns/1ps
module lat_rd_responder_bench;
  localparam int DEPTH = 4;
  localparam int HIT   = 2;
  localparam int MISS  = 5;
  localparam logic [31:0] PAT = 32'h5A3C_96E1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ar_valid = 1'b0, ar_ready;
  logic [3:0]  ar_id = '0;
  logic [31:0] ar_addr = '0;
  logic [7:0]  ar_len = '0;
  logic        r_valid, r_ready = 1'b0, r_last;
  logic [3:0]  r_id;
  logic [31:0] r_data;
  logic [1:0]  r_resp;

  always #2.5 clk = ~clk;

  lat_rd_responder #(
    .ID_W(4), .ADDR_W(32), .LEN_W(8), .DATA_W(32), .DEPTH(DEPTH),
    .HIT_DLY(HIT), .MISS_PEN(MISS), .ROW_LSB(8), .ROW_W(4), .TIME_W(16),
    .PATTERN(PAT)
  ) u_lat_rd_responder (
    .aclk(clk), .aresetn(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len), .r_valid(r_valid),
    .r_ready(r_ready), .r_id(r_id), .r_data(r_data), .r_resp(r_resp),
    .r_last(r_last)
  );

  typedef struct { logic [3:0] id; logic [31:0] addr; int len; int due; } req_t;

  req_t        mq[$];
  int          m_now, m_left, m_row, cyc, n_vec, n_bad, policy;
  bit          m_act, m_open;
  logic [3:0]  m_id;
  logic [31:0] m_addr, lfsr;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // behavioural model of one clock edge
  task automatic model_edge(input bit av, input logic [3:0] id, input logic [31:0] ad,
                            input int ln, input bit rr);
    bit ar_hs, r_hs, fin, ld;
    req_t e;
    int d;
    ar_hs = av && (mq.size() < DEPTH);
    r_hs  = m_act && rr;
    fin   = r_hs && (m_left == 0);
    ld    = (!m_act || fin) && (mq.size() > 0) && (m_now >= mq[0].due);
    if (ld) begin
      e = mq.pop_front();
      m_act = 1; m_id = e.id; m_addr = e.addr; m_left = e.len;
    end else if (fin) begin
      m_act = 0;
    end else if (r_hs) begin
      m_addr = m_addr + 4; m_left--;
    end
    if (ar_hs) begin
      d = (m_open && (int'(ad[11:8]) == m_row)) ? HIT : HIT + MISS;
      e.id = id; e.addr = ad; e.len = ln; e.due = m_now + d;
      mq.push_back(e);
      m_open = 1; m_row = int'(ad[11:8]);
    end
    m_now++;
  endtask

  task automatic step(input bit av, input logic [3:0] id, input logic [31:0] ad, input int ln);
    bit rr;
    case (policy)
      0: rr = 1'b1;
      1: rr = (cyc % 3) != 1;
      default: rr = 1'b0;
    endcase
    ar_valid = av; ar_id = id; ar_addr = ad; ar_len = 8'(ln); r_ready = rr;
    chk("R5 ar_ready", {63'd0, ar_ready}, {63'd0, mq.size() < DEPTH});
    chk("R2 R3 R4 R10 r_valid", {63'd0, r_valid}, {63'd0, m_act});
    if (m_act) begin
      chk("R6 r_id", {60'd0, r_id}, {60'd0, m_id});
      chk("R8 R9 r_data", {32'd0, r_data}, {32'd0, m_addr ^ PAT});
      chk("R7 r_last", {63'd0, r_last}, {63'd0, m_left == 0});
      chk("R8 r_resp", {62'd0, r_resp}, 64'd0);
    end
    model_edge(av, id, ad, ln, rr);
    cyc++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] id, input logic [31:0] ad, input int ln);
    bit room;
    forever begin
      room = mq.size() < DEPTH;
      step(1'b1, id, ad, ln);
      if (room) break;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 32'd0, 0);
  endtask

  task automatic drain();
    policy = 0;
    while (m_act || mq.size() > 0) idle(1);
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung run, expected completion");
    summary();
  end

  initial begin
    n_vec = 0; n_bad = 0; cyc = 0; policy = 0;
    m_now = 0; m_act = 0; m_open = 0; m_row = 0; m_left = 0; m_id = '0; m_addr = '0;
    lfsr = 32'h1D2C_3B4A;
    repeat (3) @(negedge clk);
    chk("R1 ar_ready in reset", {63'd0, ar_ready}, 64'd1);
    chk("R1 r_valid in reset", {63'd0, r_valid}, 64'd0);
    rst_n = 1'b1;
    chk("R1 ar_ready after release", {63'd0, ar_ready}, 64'd1);

    // first read after reset: miss (R3), then same-row hit (R2)
    issue(4'd1, 32'h0000_0310, 0);
    idle(HIT + MISS + 3);
    issue(4'd2, 32'h0000_0340, 3);
    idle(HIT + 6);
    // row change then back (R3)
    issue(4'd3, 32'h0000_0520, 1);
    idle(12);
    issue(4'd4, 32'h0000_0300, 0);
    idle(12);

    // fill queue with the return channel stalled (R5, R9)
    policy = 2;
    for (int k = 0; k < 5; k++) issue(4'(5 + k), 32'h0000_0300 + 32'(k * 16), 2);
    idle(12);
    policy = 1;
    issue(4'd10, 32'h0000_0700, 1);
    drain();

    // back-to-back hits, due already passed (R10)
    policy = 2;
    for (int k = 0; k < 4; k++) issue(4'(11 + k), 32'h0000_0700 + 32'(k * 8), 1);
    idle(8);
    policy = 0;
    drain();

    // mixed traffic
    for (int k = 0; k < 80; k++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      policy = (lfsr[13:12] == 2'd0) ? 1 : 0;
      issue(lfsr[19:16], {20'd0, 4'(lfsr[1:0] + 4'd2), lfsr[9:4], 2'b00}, int'(lfsr[22:20]));
      if (lfsr[15:14] != 2'd0) idle(int'(lfsr[15:14]));
    end
    drain();
    summary();
  end

endmodule